// File: doc/BRIEF.md
# File-Register Clear, Complement and Decrement Unit

This block is the execution stage for four single-operand operations in an accumulator-plus-register-file machine. It holds a 128-entry, 8-bit register file selected by a 7-bit address, an 8-bit working accumulator, and a zero flag. Each cycle it takes one operation code, an address and a destination bit. It reads the addressed register, forms the result and writes it either to the accumulator or back to the register. It also updates the zero flag. The read, modify and write all complete in a single clock.

The two operations that clear always force the zero flag high. Complement and decrement take their destination from the destination bit: 0 selects the accumulator and 1 selects the source register. Both set the zero flag from their own 8-bit result. The accumulator and the flag are registered outputs. The contents of the register file are observed by complementing a register into the accumulator.

Top module: `fileop_unit`

## Requirements
- R1: A synchronous active-high reset sets the accumulator to 00h and the zero flag to 0. After reset, every register reads as 00h.
- R2: Operation code 0 (idle) and the unused codes 5, 6 and 7 change neither the accumulator, the zero flag nor any register.
- R3: Code 1 (clear register) writes 00h to the addressed register and sets the zero flag to 1. It leaves the accumulator unchanged and ignores the destination bit.
- R4: Code 2 (clear accumulator) writes 00h to the accumulator and sets the zero flag to 1. It leaves every register unchanged.
- R5: Code 3 (complement) with the destination bit at 0 writes the bitwise inverse of the addressed register to the accumulator. The register keeps its value.
- R6: Code 3 with the destination bit at 1 writes the inverse back to the addressed register. The accumulator keeps its value.
- R7: Code 4 (decrement) writes the register value minus one. The destination rule is the same as for complement.
- R8: Decrementing 00h wraps to FFh, and the zero flag is cleared.
- R9: After complement or decrement, the zero flag is 1 exactly when the 8-bit result is 00h.
- R10: An operation that follows a register write in the very next cycle reads the updated value.
- R11: Every one of the 128 addresses, including 0 and 127, selects its own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code: 0 idle, 1 clear register, 2 clear accumulator, 3 complement, 4 decrement, others idle |
| addr_i | input | 7 | Register file address |
| dst_i | input | 1 | Destination: 0 accumulator, 1 addressed register |
| acc_o | output | 8 | Working accumulator, registered |
| zero_o | output | 1 | Zero flag, registered |

## Verification
A register is walked through a chain of complement and decrement steps with both destination values. This separates writes into the accumulator from writes into the register file, because the accumulator must hold still whenever the register is the target. The value 01h is decremented to reach a zero result, and FFh is complemented to reach one. Both values show that the flag follows the result rather than the operation. Decrementing 00h, using addresses 0 and 127, and issuing ops back to back expose wrap, aliasing and stale-read faults. Unused codes sent with the destination bit set show whether any write leaks through.

// File: rtl/fileop_pkg.sv
package fileop_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_CLRF = 3'd1,
    OP_CLRA = 3'd2,
    OP_INV  = 3'd3,
    OP_DEC  = 3'd4
  } op_e;
endpackage

// File: rtl/fileop_regfile.sv
module fileop_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // Storage without reset so it maps onto distributed RAM
  logic [DATA_W-1:0] mem [DEPTH];
  // One written-since-reset bit per entry gives the reset value
  logic [DEPTH-1:0]  written;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     written <= '0;
    else if (we) written[waddr] <= 1'b1;
  end

  assign rdata = written[raddr] ? mem[raddr] : '0;

  // R10
  write_then_read_chk: assert property (@(posedge clk) disable iff (rst)
    (we && raddr == waddr) |=> (raddr != $past(waddr)) || (rdata == $past(wdata)));
endmodule

// File: rtl/fileop_alu.sv
module fileop_alu
  import fileop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic              dst,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              acc_we,
  output logic              reg_we,
  output logic              flag_we
);
  always_comb begin
    result  = '0;
    acc_we  = 1'b0;
    reg_we  = 1'b0;
    flag_we = 1'b0;
    unique case (op)
      OP_CLRF: begin
        reg_we  = 1'b1;
        flag_we = 1'b1;
      end
      OP_CLRA: begin
        acc_we  = 1'b1;
        flag_we = 1'b1;
      end
      OP_INV: begin
        result  = ~operand;
        acc_we  = ~dst;
        reg_we  = dst;
        flag_we = 1'b1;
      end
      OP_DEC: begin
        result  = operand - DATA_W'(1);
        acc_we  = ~dst;
        reg_we  = dst;
        flag_we = 1'b1;
      end
      default: ;
    endcase
  end

  // R6
  single_target_chk: assert final (!(acc_we && reg_we));
endmodule

// File: rtl/fileop_unit.sv
module fileop_unit
  import fileop_pkg::*;
#(
  parameter int DW = fileop_pkg::DATA_W,
  parameter int AW = fileop_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dst_i,
  output logic [DW-1:0] acc_o,
  output logic          zero_o
);
  op_e           op;
  logic [DW-1:0] operand;
  logic [DW-1:0] result;
  logic          acc_we;
  logic          reg_we;
  logic          flag_we;

  assign op = op_e'(op_i);

  fileop_regfile #(.DATA_W(DW), .ADDR_W(AW)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .raddr (addr_i),
    .rdata (operand),
    .we    (reg_we),
    .waddr (addr_i),
    .wdata (result)
  );

  fileop_alu #(.DATA_W(DW)) u_alu (
    .op      (op),
    .dst     (dst_i),
    .operand (operand),
    .result  (result),
    .acc_we  (acc_we),
    .reg_we  (reg_we),
    .flag_we (flag_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o  <= '0;
      zero_o <= 1'b0;
    end else begin
      if (acc_we)  acc_o  <= result;
      if (flag_we) zero_o <= (result == '0);
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd0 || op_i > 3'd4) |=> $stable(acc_o) && $stable(zero_o));

  // R4
  clear_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd2) |=> (acc_o == '0) && zero_o);

  // R3
  clear_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd1) |=> zero_o && $stable(acc_o));

  // R9
  acc_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_i == 3'd3 || op_i == 3'd4) && !dst_i) |=> (zero_o == (acc_o == '0)));

  // R6
  reg_target_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_i == 3'd3 || op_i == 3'd4) && dst_i) |=> $stable(acc_o));
endmodule

// File: tb/sim_fileop_unit.sv
`timescale 1ns/1ps
module sim_fileop_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_i = 3'd0;
  logic [6:0] addr_i = '0;
  logic       dst_i = 1'b0;
  logic [7:0] acc_o;
  logic       zero_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fileop_unit u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .addr_i(addr_i),
    .dst_i(dst_i), .acc_o(acc_o), .zero_o(zero_o)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [6:0] a;
    logic       d;
    logic [7:0] w;
    logic       z;
    logic [3:0] r;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{3'd3, 7'd5,   1'b1, 8'h00, 1'b0, 4'd6},  // R6 r5 -> FF
    '{3'd3, 7'd5,   1'b0, 8'h00, 1'b1, 4'd5},  // R5 ~FF = 00
    '{3'd4, 7'd5,   1'b1, 8'h00, 1'b0, 4'd7},  // R7 r5 -> FE
    '{3'd4, 7'd5,   1'b0, 8'hFD, 1'b0, 4'd7},  // R7 to acc
    '{3'd2, 7'd5,   1'b1, 8'h00, 1'b1, 4'd4},  // R4
    '{3'd3, 7'd5,   1'b0, 8'h01, 1'b0, 4'd4},  // R4 r5 still FE
    '{3'd3, 7'd5,   1'b1, 8'h01, 1'b0, 4'd6},  // R6 r5 -> 01
    '{3'd4, 7'd5,   1'b0, 8'h00, 1'b1, 4'd9},  // R9 01-1 = 00
    '{3'd4, 7'd9,   1'b0, 8'hFF, 1'b0, 4'd8},  // R8 wrap to acc
    '{3'd4, 7'd9,   1'b1, 8'hFF, 1'b0, 4'd8},  // R8 r9 -> FF
    '{3'd3, 7'd9,   1'b0, 8'h00, 1'b1, 4'd10}, // R10 sees FF
    '{3'd1, 7'd5,   1'b0, 8'h00, 1'b1, 4'd3},  // R3 d ignored
    '{3'd6, 7'd5,   1'b1, 8'h00, 1'b1, 4'd2},  // R2 unused code
    '{3'd3, 7'd5,   1'b0, 8'hFF, 1'b0, 4'd3},  // R3 r5 cleared
    '{3'd0, 7'd5,   1'b1, 8'hFF, 1'b0, 4'd2},  // R2 idle
    '{3'd4, 7'd127, 1'b1, 8'hFF, 1'b0, 4'd11}, // R11 r127 -> FF
    '{3'd4, 7'd0,   1'b0, 8'hFF, 1'b0, 4'd11}, // R11 r0 still 00
    '{3'd3, 7'd127, 1'b0, 8'h00, 1'b1, 4'd11}, // R11 r127 is FF
    '{3'd7, 7'd9,   1'b1, 8'h00, 1'b1, 4'd2}   // R2 unused code
  };

  task automatic check(input string tag, input logic [7:0] ew, input logic ez);
    n_run++;
    if (acc_o !== ew || zero_o !== ez) begin
      n_fail++;
      $display("FAIL %s: acc=%h zero=%b expected acc=%h zero=%b",
               tag, acc_o, zero_o, ew, ez);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [6:0] a, input logic d);
    op_i = o; addr_i = a; dst_i = d;
    @(negedge clk);
    op_i = 3'd0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 8'h00, 1'b0);
    issue(3'd3, 7'd64, 1'b0);
    check("R1", 8'hFF, 1'b0);
    issue(3'd2, 7'd0, 1'b0);
    check("R4", 8'h00, 1'b1);
    issue(3'd3, 7'd64, 1'b1);  // r64 -> FF, flag cleared
    check("R6", 8'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      op_i = TBL[i].op; addr_i = TBL[i].a; dst_i = TBL[i].d;
      @(negedge clk);
      check($sformatf("R%0d", TBL[i].r), TBL[i].w, TBL[i].z);
    end
    op_i = 3'd0;

    // R1: reset in mid-run clears accumulator, flag and written registers
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", 8'h00, 1'b0);
    issue(3'd3, 7'd127, 1'b0);
    check("R1", 8'hFF, 1'b0);
    issue(3'd3, 7'd64, 1'b0);
    check("R1", 8'hFF, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule